// File: doc/BRIEF.md
# Tagged Pointer Array Length Unit

This unit answers an array-length query for an object reference that carries a 16-bit tag in its upper bits. The core hands over one 64-bit pointer through a valid/ready request channel. If the tag holds an ordinary value, that value is the array length and the unit answers without touching memory. If the tag holds the all-ones marker, the tag carries no length, so the unit reads a 32-bit header word from memory at the untagged base plus a fixed offset and returns that word.

The unit holds one query at a time. It takes no new request until the core has accepted the current response. The memory side is a read port with one outstanding access: an address phase with its own valid/ready handshake, then a single data-valid beat. A flag on the response tells whether the length came from the tag or from memory.

Top module: `tagptr_len_unit`

## Requirements
- R1: After reset `req_ready` is 1, and `rsp_valid` and `mem_rd_valid` are 0.
- R2: `req_ready` is 1 only while no query is in progress. It stays 0 from acceptance until the cycle after the response handshake (`rsp_valid` and `rsp_ready` both 1).
- R3: When the tag (pointer bits [63:48]) is in 0x0000..0xFFFE, `rsp_len` equals the tag, zero-extended to 32 bits.
- R4: On a tag-resolved query, `rsp_valid` rises in the cycle after acceptance and `mem_rd_valid` stays 0 for the whole query.
- R5: When the tag equals 0xFFFF, `mem_rd_valid` rises in the cycle after acceptance. `mem_rd_addr` is then pointer bits [47:0] plus 0x10, taken modulo 2^48, with the tag cleared.
- R6: While `mem_rd_valid` is 1 and `mem_rd_ready` is 0, the read request and `mem_rd_addr` are held unchanged.
- R7: In the memory path, `rsp_valid` rises in the cycle after the cycle in which `mem_rd_data_valid` is accepted. `rsp_len` then equals the `mem_rd_data` of that cycle.
- R8: `rsp_from_mem` is 0 for a length taken from the tag and 1 for a length read from memory.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_len` and `rsp_from_mem` are held unchanged.
- R10: `mem_rd_data_valid` is ignored unless a read address has been accepted and its data is still pending.
- R11: `req_valid` and `req_ptr` are ignored while a query is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Query offered |
| req_ready | output | 1 | Unit can accept a query |
| req_ptr | input | 64 | Tagged pointer: tag [63:48], base [47:0] |
| rsp_valid | output | 1 | Length result available |
| rsp_ready | input | 1 | Core takes the result |
| rsp_len | output | 32 | Array length |
| rsp_from_mem | output | 1 | 1 when the length came from the header read |
| mem_rd_valid | output | 1 | Header read address offered |
| mem_rd_ready | input | 1 | Memory takes the address |
| mem_rd_addr | output | 48 | Header address, base plus offset |
| mem_rd_data_valid | input | 1 | Read data beat |
| mem_rd_data | input | 32 | Header word |

## Verification
The assertions check the following on every cycle: the request channel is never ready while a response is pending, the read request and the response are held while stalled, the address and the length follow from the accepted pointer, and a tag-resolved query never touches memory. Some behaviour only the bench scenarios can show. These are: the end-point tag values 0x0000 and 0xFFFE, address wrap-around at the top of the 48-bit base range, stray data beats and stray requests that must leave the result unchanged, and back-to-back queries that mix both paths.

// File: rtl/tplu_pkg.sv
package tplu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WAIT = 2'd2,
    ST_RSP  = 2'd3
  } tplu_state_e;
endpackage

// File: rtl/tplu_decode.sv
module tplu_decode #(
  parameter int PTR_W = 64,
  parameter int TAG_W = 16,
  parameter int LEN_W = 32,
  parameter logic [TAG_W-1:0] SENTINEL = '1
) (
  input  logic [PTR_W-1:0]       ptr,
  output logic [LEN_W-1:0]       tag_len,
  output logic                   tag_is_marker,
  output logic [PTR_W-TAG_W-1:0] base
);
  localparam int BASE_W = PTR_W - TAG_W;

  function automatic logic [TAG_W-1:0] tag_field(input logic [PTR_W-1:0] p);
    return p[PTR_W-1:BASE_W];
  endfunction

  function automatic logic [LEN_W-1:0] widen(input logic [TAG_W-1:0] t);
    return {{(LEN_W-TAG_W){1'b0}}, t};
  endfunction

  always_comb begin
    tag_len       = widen(tag_field(ptr));
    tag_is_marker = (tag_field(ptr) == SENTINEL);
    base          = ptr[BASE_W-1:0];
  end
endmodule

// File: rtl/tplu_addr.sv
module tplu_addr #(
  parameter int BASE_W  = 48,
  parameter int HDR_OFS = 16
) (
  input  logic [BASE_W-1:0] base,
  output logic [BASE_W-1:0] hdr_addr
);
  localparam logic [BASE_W-1:0] OFS = BASE_W'(HDR_OFS);

  function automatic logic [BASE_W-1:0] header_of(input logic [BASE_W-1:0] b);
    return b + OFS;
  endfunction

  assign hdr_addr = header_of(base);
endmodule

// File: rtl/tplu_fsm.sv
module tplu_fsm
  import tplu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        tag_is_marker,
  input  logic        mem_rd_ready,
  input  logic        mem_rd_data_valid,
  input  logic        rsp_ready,
  output tplu_state_e state,
  output logic        acc_fast,
  output logic        acc_slow,
  output logic        addr_take,
  output logic        data_take,
  output logic        rsp_done
);
  tplu_state_e nxt;

  always_comb begin
    acc_fast  = (state == ST_IDLE) && req_valid && !tag_is_marker;
    acc_slow  = (state == ST_IDLE) && req_valid &&  tag_is_marker;
    addr_take = (state == ST_RD)   && mem_rd_ready;
    data_take = (state == ST_WAIT) && mem_rd_data_valid;
    rsp_done  = (state == ST_RSP)  && rsp_ready;
    nxt = state;
    unique case (state)
      ST_IDLE: if (acc_fast) nxt = ST_RSP; else if (acc_slow) nxt = ST_RD;
      ST_RD:   if (addr_take) nxt = ST_WAIT;
      ST_WAIT: if (data_take) nxt = ST_RSP;
      ST_RSP:  if (rsp_done)  nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/tagptr_len_unit.sv
module tagptr_len_unit #(
  parameter int PTR_W   = 64,
  parameter int TAG_W   = 16,
  parameter int LEN_W   = 32,
  parameter int HDR_OFS = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [PTR_W-1:0]       req_ptr,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [LEN_W-1:0]       rsp_len,
  output logic                   rsp_from_mem,
  output logic                   mem_rd_valid,
  input  logic                   mem_rd_ready,
  output logic [PTR_W-TAG_W-1:0] mem_rd_addr,
  input  logic                   mem_rd_data_valid,
  input  logic [LEN_W-1:0]       mem_rd_data
);
  import tplu_pkg::*;
  localparam int BASE_W = PTR_W - TAG_W;

  logic [LEN_W-1:0]  tag_len;
  logic              tag_is_marker;
  logic [BASE_W-1:0] base;
  logic [BASE_W-1:0] hdr_addr;
  tplu_state_e       state;
  logic acc_fast, acc_slow, addr_take, data_take, rsp_done;
  logic [BASE_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic              from_mem_q;

  tplu_decode #(.PTR_W(PTR_W), .TAG_W(TAG_W), .LEN_W(LEN_W)) u_dec (
    .ptr(req_ptr), .tag_len(tag_len), .tag_is_marker(tag_is_marker), .base(base)
  );

  tplu_addr #(.BASE_W(BASE_W), .HDR_OFS(HDR_OFS)) u_addr (
    .base(base), .hdr_addr(hdr_addr)
  );

  tplu_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .tag_is_marker(tag_is_marker),
    .mem_rd_ready(mem_rd_ready), .mem_rd_data_valid(mem_rd_data_valid),
    .rsp_ready(rsp_ready), .state(state), .acc_fast(acc_fast), .acc_slow(acc_slow),
    .addr_take(addr_take), .data_take(data_take), .rsp_done(rsp_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q     <= '0;
      len_q      <= '0;
      from_mem_q <= 1'b0;
    end else begin
      if (acc_slow) addr_q <= hdr_addr;
      if (acc_fast) begin
        len_q      <= tag_len;
        from_mem_q <= 1'b0;
      end else if (data_take) begin
        len_q      <= mem_rd_data;
        from_mem_q <= 1'b1;
      end
    end
  end

  assign req_ready    = (state == ST_IDLE);
  assign mem_rd_valid = (state == ST_RD);
  assign rsp_valid    = (state == ST_RSP);
  assign mem_rd_addr  = addr_q;
  assign rsp_len      = len_q;
  assign rsp_from_mem = from_mem_q;
endmodule

// File: rtl/tplu_chk.sv
module tplu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [63:0] req_ptr,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_len,
  input logic        rsp_from_mem,
  input logic        mem_rd_valid,
  input logic        mem_rd_ready,
  input logic [47:0] mem_rd_addr,
  input logic [31:0] mem_rd_data,
  input logic        acc_fast,
  input logic        acc_slow,
  input logic        data_take
);
  // R2
  busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || mem_rd_valid) |-> !req_ready);
  // R3
  tag_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fast |=> rsp_valid && !rsp_from_mem && rsp_len == {16'h0, $past(req_ptr[63:48])});
  // R4
  fast_nomem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fast |=> !mem_rd_valid);
  // R5
  hdr_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_slow |=> mem_rd_valid && mem_rd_addr == $past(req_ptr[47:0]) + 48'h10);
  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> mem_rd_valid && $stable(mem_rd_addr));
  // R7
  mem_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_take |=> rsp_valid && rsp_from_mem && rsp_len == $past(mem_rd_data));
  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_len) && $stable(rsp_from_mem));
endmodule

bind tagptr_len_unit tplu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ptr(req_ptr), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_len(rsp_len),
  .rsp_from_mem(rsp_from_mem), .mem_rd_valid(mem_rd_valid),
  .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
  .acc_fast(acc_fast), .acc_slow(acc_slow), .data_take(data_take)
);

// File: tb/test_tagptr_len_unit.sv
`timescale 1ns/1ps
module test_tagptr_len_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [63:0] req_ptr = '0;
  logic rsp_ready = 1'b0;
  logic mem_rd_ready = 1'b0;
  logic mem_rd_data_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic req_ready, rsp_valid, rsp_from_mem, mem_rd_valid;
  logic [31:0] rsp_len;
  logic [47:0] mem_rd_addr;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tagptr_len_unit i_tagptr_len_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_ptr(req_ptr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_len(rsp_len), .rsp_from_mem(rsp_from_mem), .mem_rd_valid(mem_rd_valid),
    .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data_valid(mem_rd_data_valid), .mem_rd_data(mem_rd_data)
  );

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", r, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase 0 free, 1 address pending, 2 data pending, 3 answer
  int   m_ph = 0;
  logic [31:0] m_len = '0;
  logic m_mem = 1'b0;
  logic [47:0] m_addr = '0;

  always @(posedge clk) begin
    if (!rst_n) m_ph = 0;
    else begin
      case (m_ph)
        0: if (req_valid) begin
             if (req_ptr[63:48] != 16'hFFFF) begin
               m_len = 32'(req_ptr[63:48]); m_mem = 1'b0; m_ph = 3;
             end else begin
               m_addr = 48'((49'(req_ptr[47:0]) + 49'd16) % (49'd1 << 48)); m_ph = 1;
             end
           end
        1: if (mem_rd_ready) m_ph = 2;
        2: if (mem_rd_data_valid) begin m_len = mem_rd_data; m_mem = 1'b1; m_ph = 3; end
        default: if (rsp_ready) m_ph = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2", req_ready, (m_ph == 0) ? 1 : 0);
      chk("R4", mem_rd_valid, (m_ph == 1) ? 1 : 0);
      chk("R9", rsp_valid, (m_ph == 3) ? 1 : 0);
      if (m_ph == 1) chk("R6", mem_rd_addr, m_addr);
      if (m_ph == 3) begin
        chk("R7", rsp_len, m_len);
        chk("R8", rsp_from_mem, m_mem);
      end
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic query(input logic [63:0] p, input int rdy_dly, input int lat,
                       input logic [31:0] word, input int rsp_dly);
    logic [31:0] exp_len;
    logic exp_mem;
    exp_mem = (p[63:48] == 16'hFFFF);
    exp_len = exp_mem ? word : 32'(p[63:48]);
    req_valid = 1'b1; req_ptr = p;
    step();
    req_valid = 1'b0; req_ptr = ~p;
    if (!exp_mem) begin
      chk("R3", rsp_len, exp_len);
      chk("R4", {mem_rd_valid, rsp_valid}, 2'b01);
    end else begin
      chk("R5", {mem_rd_valid, mem_rd_addr}, {1'b1, p[47:0] + 48'h10});
      for (int i = 0; i < rdy_dly; i++) begin
        mem_rd_data_valid = (i == 0); mem_rd_data = 32'hBAD0_0000;  // R10 stray beat
        step();
        mem_rd_data_valid = 1'b0;
        chk("R6", mem_rd_valid, 1);
      end
      mem_rd_ready = 1'b1;
      step();
      mem_rd_ready = 1'b0;
      for (int i = 0; i < lat; i++) step();
      mem_rd_data_valid = 1'b1; mem_rd_data = word;
      step();
      mem_rd_data_valid = 1'b0; mem_rd_data = 32'hDEAD_BEEF;
      chk("R7", {rsp_valid, rsp_len}, {1'b1, exp_len});
    end
    chk("R8", rsp_from_mem, exp_mem);
    for (int i = 0; i < rsp_dly; i++) begin
      req_valid = 1'b1; req_ptr = 64'h0042_0000_0000_1000;  // R11 stray request
      mem_rd_data_valid = 1'b1;                              // R10 stray beat
      step();
      req_valid = 1'b0; mem_rd_data_valid = 1'b0;
      chk("R11", {rsp_valid, rsp_len}, {1'b1, exp_len});
      chk("R10", rsp_from_mem, exp_mem);
    end
    rsp_ready = 1'b1;
    step();
    rsp_ready = 1'b0;
    chk("R2", {req_ready, rsp_valid}, 2'b10);
  endtask

  initial begin
    repeat (3) step();
    chk("R1", {req_ready, rsp_valid, mem_rd_valid}, 3'b100);
    rst_n = 1'b1;
    step();
    chk("R1", {req_ready, rsp_valid, mem_rd_valid}, 3'b100);
    mem_rd_data_valid = 1'b1; mem_rd_data = 32'h1111;  // R10 idle beat
    step();
    mem_rd_data_valid = 1'b0;
    chk("R10", {req_ready, rsp_valid}, 2'b10);
    query(64'h0000_1234_5678_9ABC, 0, 0, 0, 0);
    query(64'h1234_0000_0000_0008, 0, 0, 0, 2);
    query(64'hFFFE_FFFF_FFFF_FFFF, 0, 0, 0, 0);
    query(64'hFFFF_0000_0040_0000, 0, 0, 32'h0000_0007, 0);
    query(64'hFFFF_FFFF_FFFF_FFF8, 3, 2, 32'hFFFF_FFFF, 3);
    query(64'h0001_0000_0000_0100, 0, 0, 0, 1);
    query(64'hFFFF_7000_0000_0000, 1, 4, 32'h0001_0000, 0);
    query(64'h8000_0000_0000_0000, 0, 0, 0, 0);
    repeat (2) step();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(20 * 200000);
    done = 1'b1;
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule